// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block holds the interrupt presentation state of a single processor. Its central register is 32 bits wide. Bits 31:24 hold the processor's current priority and bits 23:0 hold the number of the source waiting to be taken. A zero source field means that nothing waits. Beside it the block keeps two more values: the priority at which a self-directed inter-processor interrupt is wanted, and the priority of the source that is currently latched. Lower numbers are more favoured. Priority 0xFF is the least favoured level and acts as a mask.

A source controller offers interrupts as (source, priority) pairs. Every offer is arbitrated at once. When an offer loses, or when a latched source is pushed out, the block sends a reject pulse that carries the source number back to the source side. It never queues anything. The processor side can write the current priority, write the inter-processor priority, read-and-accept the register, and signal end of interrupt. An end of interrupt is passed to the sources as a pulse, followed by a resend request so that sources rejected earlier offer themselves again. The inter-processor interrupt uses the fixed source number 2.

Each event is sampled on a rising clock edge. The resulting state, the interrupt line and the reject, end-of-interrupt and resend pulses all appear one cycle later.

Top module: `intr_present_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000 and the interrupt line is low. No pulse is raised. The latched and inter-processor priorities are both 0xFF, so a first accept leaves the register at 0xFF000000.
- R2: An accept returns the register's value as it stood before the edge. The next cycle shows the line low, the source field zero, and bits 31:24 equal to the priority that was latched. The latched priority then becomes 0xFF.
- R3: An offer is refused when its priority is greater than or equal to bits 31:24, or when a nonzero source is latched whose priority is less than or equal to the offered one. A refused offer gives a reject pulse carrying the offered source and leaves the state unchanged.
- R4: An offer that is not refused latches its source and priority and raises the line. If a nonzero source was already latched, that source is rejected in the same cycle.
- R5: A write of the inter-processor priority always stores the value. It starts the inter-processor check only if the value is below bits 31:24. Otherwise the register and the line are unchanged.
- R6: The inter-processor check does nothing when a nonzero source is latched with a priority at or below the inter-processor priority. Otherwise it rejects any nonzero latched source, latches source 2 with the inter-processor priority, and raises the line.
- R7: An end-of-interrupt write of a 32-bit value D copies D[31:24] into bits 31:24. It pulses the end-of-interrupt output carrying D[23:0] and pulses resend. If the inter-processor priority is below D[31:24], it then runs the R6 check.
- R8: A current-priority write with a value V below the old priority stores V. If a nonzero source is latched with a priority at or above V, that write also clears the source field, sets the latched priority to 0xFF, lowers the line and rejects that source. A lowering write with nothing to clear does nothing more.
- R9: A current-priority write that does not lower the priority stores V and pulses resend. If the inter-processor priority is below V, it then runs the R6 check.
- R10: When several processor commands arrive together, only one is carried out: accept first, then end of interrupt, then current-priority write, then inter-processor write. An offer arriving in the same cycle as any command is discarded without a reject.
- R11: An offer with source number 0 is ignored: there is no pulse and no change of state.
- R12: Every pulse output is high for exactly the one cycle after the event that caused it. After an idle cycle all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Source controller offers an interrupt |
| req_src | input | 24 | Offered source number |
| req_prio | input | 8 | Offered priority |
| cppr_wr | input | 1 | Processor writes the current priority |
| cppr_data | input | 8 | New current priority |
| ipi_wr | input | 1 | Processor writes the inter-processor priority |
| ipi_data | input | 8 | New inter-processor priority |
| accept_rd | input | 1 | Processor accepts the pending interrupt |
| eoi_wr | input | 1 | Processor signals end of interrupt |
| eoi_data | input | 32 | Priority to restore (31:24) and finished source (23:0) |
| xirr_o | output | 32 | Current register: priority 31:24, pending source 23:0 |
| irq_o | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the sources |
| eoi_src | output | 24 | Source being retired |
| resend_o | output | 1 | Sources asked to offer rejected interrupts again |

## Verification
On every cycle the assertions check five things:
- an offer at or above the current priority is bounced back with its own source number;
- an accept always leaves the line low and the source field empty;
- an end of interrupt always produces both the retire pulse and the resend pulse;
- a lowering priority write that is forced to clear a source rejects exactly that source;
- the line is high exactly when a source is latched and no pulse follows an idle cycle.

Only the bench's scenarios can show the rest. The full arbitration between a latched source and a newcomer across every priority ordering is one of these, as are the inter-processor check after end of interrupt and after non-lowering priority writes. So are the command precedence rules, and the value the accept returns after a chain of offers.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int REG_W  = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_REQ,
    EV_IPI,
    EV_CPPR,
    EV_EOI,
    EV_ACCEPT
  } ipr_ev_e;

  typedef struct packed {
    logic [PRIO_W-1:0] cppr;
    logic [SRC_W-1:0]  src;
    logic [PRIO_W-1:0] pend;
    logic [PRIO_W-1:0] mfrr;
    logic              irq;
  } ipr_state_t;

  // An offer loses if the processor will not take it, or if the holder is at least as favoured.
  function automatic logic offer_refused(
    input logic [PRIO_W-1:0] prio,
    input logic [PRIO_W-1:0] cppr,
    input logic [SRC_W-1:0]  held_src,
    input logic [PRIO_W-1:0] held_pend);
    return (prio >= cppr) || ((held_src != '0) && (held_pend <= prio));
  endfunction

  // The inter-processor interrupt takes over unless the holder is at least as favoured.
  function automatic logic ipi_takes_over(
    input logic [PRIO_W-1:0] mfrr,
    input logic [SRC_W-1:0]  held_src,
    input logic [PRIO_W-1:0] held_pend);
    return !((held_src != '0) && (held_pend <= mfrr));
  endfunction

endpackage

// File: rtl/ipr_event_sel.sv
module ipr_event_sel
  import ipr_pkg::*;
(
  input  logic             accept_rd,
  input  logic             eoi_wr,
  input  logic             cppr_wr,
  input  logic             ipi_wr,
  input  logic             req_valid,
  input  logic [SRC_W-1:0] req_src,
  output ipr_ev_e          ev
);
  // Processor commands win; a concurrent offer is discarded (R10), a zero source never counts (R11).
  always_comb begin
    if (accept_rd)                         ev = EV_ACCEPT;
    else if (eoi_wr)                       ev = EV_EOI;
    else if (cppr_wr)                      ev = EV_CPPR;
    else if (ipi_wr)                       ev = EV_IPI;
    else if (req_valid && req_src != '0)   ev = EV_REQ;
    else                                   ev = EV_NONE;
  end
endmodule

// File: rtl/ipr_next.sv
module ipr_next
  import ipr_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = SRC_W'(2)
) (
  input  ipr_state_t        cur,
  input  ipr_ev_e           ev,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] cppr_data,
  input  logic [PRIO_W-1:0] ipi_data,
  input  logic [REG_W-1:0]  eoi_data,
  output ipr_state_t        nxt,
  output logic              rej_v,
  output logic [SRC_W-1:0]  rej_s,
  output logic              eoi_v,
  output logic [SRC_W-1:0]  eoi_s,
  output logic              resend,
  output logic              ipi_check
);
  always_comb begin
    nxt       = cur;
    rej_v     = 1'b0;
    rej_s     = '0;
    eoi_v     = 1'b0;
    eoi_s     = '0;
    resend    = 1'b0;
    ipi_check = 1'b0;
    unique case (ev)
      EV_REQ: begin
        if (offer_refused(req_prio, cur.cppr, cur.src, cur.pend)) begin
          rej_v = 1'b1;
          rej_s = req_src;
        end else begin
          if (cur.src != '0) begin
            rej_v = 1'b1;
            rej_s = cur.src;
          end
          nxt.src  = req_src;
          nxt.pend = req_prio;
          nxt.irq  = 1'b1;
        end
      end
      EV_IPI: begin
        nxt.mfrr  = ipi_data;
        ipi_check = ipi_data < cur.cppr;
      end
      EV_CPPR: begin
        nxt.cppr = cppr_data;
        if (cppr_data < cur.cppr) begin
          if (cur.src != '0 && cppr_data <= cur.pend) begin
            rej_v    = 1'b1;
            rej_s    = cur.src;
            nxt.src  = '0;
            nxt.pend = PRIO_MASKED;
            nxt.irq  = 1'b0;
          end
        end else begin
          resend    = 1'b1;
          ipi_check = cur.mfrr < cppr_data;
        end
      end
      EV_EOI: begin
        nxt.cppr  = eoi_data[REG_W-1:SRC_W];
        eoi_v     = 1'b1;
        eoi_s     = eoi_data[SRC_W-1:0];
        resend    = 1'b1;
        ipi_check = cur.mfrr < eoi_data[REG_W-1:SRC_W];
      end
      EV_ACCEPT: begin
        nxt.irq  = 1'b0;
        nxt.cppr = cur.pend;
        nxt.src  = '0;
        nxt.pend = PRIO_MASKED;
      end
      default: ;
    endcase
    // Paths that run the check never alter src or pend beforehand, so cur is still the holder.
    if (ipi_check && ipi_takes_over(nxt.mfrr, cur.src, cur.pend)) begin
      if (cur.src != '0) begin
        rej_v = 1'b1;
        rej_s = cur.src;
      end
      nxt.src  = IPI_SRC;
      nxt.pend = nxt.mfrr;
      nxt.irq  = 1'b1;
    end
  end
endmodule

// File: rtl/intr_present_ctrl.sv
module intr_present_ctrl
  import ipr_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = SRC_W'(2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic              cppr_wr,
  input  logic [PRIO_W-1:0] cppr_data,
  input  logic              ipi_wr,
  input  logic [PRIO_W-1:0] ipi_data,
  input  logic              accept_rd,
  input  logic              eoi_wr,
  input  logic [REG_W-1:0]  eoi_data,
  output logic [REG_W-1:0]  xirr_o,
  output logic              irq_o,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              resend_o
);
  ipr_ev_e    ev;
  ipr_state_t st_q, st_d;
  logic              rej_v_d, eoi_v_d, resend_d, ipi_check;
  logic [SRC_W-1:0]  rej_s_d, eoi_s_d;

  ipr_event_sel u_sel (
    .accept_rd (accept_rd),
    .eoi_wr    (eoi_wr),
    .cppr_wr   (cppr_wr),
    .ipi_wr    (ipi_wr),
    .req_valid (req_valid),
    .req_src   (req_src),
    .ev        (ev)
  );

  ipr_next #(.IPI_SRC(IPI_SRC)) u_next (
    .cur       (st_q),
    .ev        (ev),
    .req_src   (req_src),
    .req_prio  (req_prio),
    .cppr_data (cppr_data),
    .ipi_data  (ipi_data),
    .eoi_data  (eoi_data),
    .nxt       (st_d),
    .rej_v     (rej_v_d),
    .rej_s     (rej_s_d),
    .eoi_v     (eoi_v_d),
    .eoi_s     (eoi_s_d),
    .resend    (resend_d),
    .ipi_check (ipi_check)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= '{cppr: '0, src: '0, pend: PRIO_MASKED, mfrr: PRIO_MASKED, irq: 1'b0};
      rej_valid <= 1'b0;
      rej_src   <= '0;
      eoi_valid <= 1'b0;
      eoi_src   <= '0;
      resend_o  <= 1'b0;
    end else begin
      st_q      <= st_d;
      rej_valid <= rej_v_d;
      rej_src   <= rej_s_d;
      eoi_valid <= eoi_v_d;
      eoi_src   <= eoi_s_d;
      resend_o  <= resend_d;
    end
  end

  assign xirr_o = {st_q.cppr, st_q.src};
  assign irq_o  = st_q.irq;

  // R3: an offer at or above the current priority comes back as a reject of itself
  a_r3_refused_bounce: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_REQ && req_prio >= xirr_o[REG_W-1:SRC_W])
      |=> (rej_valid && rej_src == $past(req_src) && xirr_o == $past(xirr_o)));

  // R2: accept always empties the source field and drops the line
  a_r2_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_ACCEPT) |=> (!irq_o && xirr_o[SRC_W-1:0] == '0));

  // R7: end of interrupt always retires the source and asks for resend
  a_r7_eoi_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_EOI) |=> (eoi_valid && resend_o && eoi_src == $past(eoi_data[SRC_W-1:0])));

  // R8: a lowering priority write that clears the holder rejects exactly that holder
  a_r8_lower_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_CPPR && cppr_data < st_q.cppr && st_q.src != '0 && cppr_data <= st_q.pend)
      |=> (!irq_o && rej_valid && rej_src == $past(st_q.src) && xirr_o[SRC_W-1:0] == '0));

  // R4: the line is high exactly while a source is latched
  a_r4_line_tracks_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (xirr_o[SRC_W-1:0] != '0));

  // R12: an idle cycle leaves every pulse low afterwards
  a_r12_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_NONE) |=> (!rej_valid && !eoi_valid && !resend_o));

  // R6: the inter-processor check never runs when the new priority is not below the current one
  a_r6_ipi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_IPI && ipi_data >= st_q.cppr) |=> (xirr_o == $past(xirr_o) && !rej_valid));

endmodule

// File: tb/sim_intr_present_ctrl.sv
`timescale 1ns/1ps
module sim_intr_present_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, req_valid, cppr_wr, ipi_wr, accept_rd, eoi_wr;
  logic [23:0] req_src;
  logic [7:0]  req_prio, cppr_data, ipi_data;
  logic [31:0] eoi_data, xirr_o;
  logic        irq_o, rej_valid, eoi_valid, resend_o;
  logic [23:0] rej_src, eoi_src;

  intr_present_ctrl u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench's own view of the block
  logic [7:0]  m_cur, m_held_prio, m_ipi;
  logic [23:0] m_held;
  logic        m_line, x_rej, x_eoi, x_rs;
  logic [23:0] x_rej_src, x_eoi_src;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic verify(string tag);
    chk({tag, " register"}, xirr_o, {m_cur, m_held});
    chk({tag, " line"}, irq_o, m_line);
    chk({tag, " reject"}, rej_valid, x_rej);
    if (x_rej) chk({tag, " reject source"}, rej_src, x_rej_src);
    chk({tag, " eoi"}, eoi_valid, x_eoi);
    if (x_eoi) chk({tag, " eoi source"}, eoi_src, x_eoi_src);
    chk({tag, " resend"}, resend_o, x_rs);
  endtask

  task automatic no_pulses;
    x_rej = 0; x_eoi = 0; x_rs = 0;
  endtask

  task automatic bounce(logic [23:0] s);
    x_rej = 1; x_rej_src = s;
  endtask

  // inter-processor check as the requirements word it (R6)
  task automatic ipi_check;
    bool_keep: begin
      if (m_held != 0 && !(m_ipi < m_held_prio)) disable bool_keep;
      if (m_held != 0) bounce(m_held);
      m_held = 24'd2; m_held_prio = m_ipi; m_line = 1;
    end
  endtask

  task automatic idle_inputs;
    req_valid = 0; cppr_wr = 0; ipi_wr = 0; accept_rd = 0; eoi_wr = 0;
  endtask

  task automatic step(string tag);
    @(negedge clk);
    idle_inputs();
    verify(tag);
  endtask

  task automatic do_req(logic [23:0] s, logic [7:0] p, string tag);
    req_valid = 1; req_src = s; req_prio = p;
    no_pulses();
    if (s != 0) begin
      if (p < m_cur && (m_held == 0 || p < m_held_prio)) begin
        if (m_held != 0) bounce(m_held);
        m_held = s; m_held_prio = p; m_line = 1;
      end else bounce(s);
    end
    step(tag);
  endtask

  task automatic do_cppr(logic [7:0] v, string tag);
    logic [7:0] old;
    cppr_wr = 1; cppr_data = v;
    no_pulses();
    old = m_cur; m_cur = v;
    if (v < old) begin
      if (m_held != 0 && v <= m_held_prio) begin
        bounce(m_held); m_held = 0; m_held_prio = 8'hFF; m_line = 0;
      end
    end else begin
      x_rs = 1;
      if (m_ipi < m_cur) ipi_check();
    end
    step(tag);
  endtask

  task automatic do_ipi(logic [7:0] v, string tag);
    ipi_wr = 1; ipi_data = v;
    no_pulses();
    m_ipi = v;
    if (v < m_cur) ipi_check();
    step(tag);
  endtask

  task automatic do_accept(string tag);
    accept_rd = 1;
    no_pulses();
    chk({tag, " accept value"}, xirr_o, {m_cur, m_held});
    m_cur = m_held_prio; m_held = 0; m_held_prio = 8'hFF; m_line = 0;
    step(tag);
  endtask

  task automatic do_eoi(logic [31:0] d, string tag);
    eoi_wr = 1; eoi_data = d;
    no_pulses();
    m_cur = d[31:24]; x_eoi = 1; x_eoi_src = d[23:0]; x_rs = 1;
    if (m_ipi < m_cur) ipi_check();
    step(tag);
  endtask

  task automatic clean(logic [7:0] level);
    do_ipi(8'hFF, "R5 park");
    do_accept("R2 drain");
    do_accept("R2 drain");
    do_cppr(level, "R8/R9 setup");
  endtask

  function automatic logic [7:0] lvl(int i);
    return (i >= 4) ? 8'hFF : 8'(i * 8'h30);
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_inputs();
    req_src = 0; req_prio = 0; cppr_data = 0; ipi_data = 0; eoi_data = 0;
    m_cur = 0; m_held = 0; m_held_prio = 8'hFF; m_ipi = 8'hFF; m_line = 0;
    no_pulses();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    verify("R1 reset state");
    do_accept("R1 first accept");
    chk("R1 priority after accept", xirr_o, 32'hFF00_0000);

    // offers against every ordering of current, held and offered priority (R3, R4)
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 5; c++) begin
          clean(lvl(a));
          if (b < 5) do_req(24'h100 + 24'(b), lvl(b), "R3/R4 first offer");
          do_req(24'h200 + 24'(c), lvl(c), "R3/R4 second offer");
          do_accept("R2 accept after offers");
        end

    // lowering priority writes against a held source (R8)
    for (int a = 0; a < 4; a++)
      for (int n = 0; n < 5; n++) begin
        clean(8'hFF);
        do_req(24'h0ABC, lvl(a), "R4 hold");
        do_cppr(lvl(n), "R8 lower");
        do_cppr(8'hFF, "R9 raise");
      end

    // inter-processor writes and checks (R5, R6, R7, R9)
    for (int a = 0; a < 5; a++)
      for (int m = 0; m < 5; m++)
        for (int h = 0; h < 2; h++) begin
          clean(lvl(a));
          if (h == 1) do_req(24'h33, 8'h50, "R4 hold");
          do_ipi(lvl(m), "R5/R6 ipi write");
          do_eoi({8'hFF, 24'h33}, "R7 eoi");
          do_cppr(8'hFF, "R9 non-lowering");
          do_accept("R2 accept");
        end

    // R11: source 0 has no effect
    clean(8'hFF);
    do_req(24'h0, 8'h10, "R11 zero source");
    @(negedge clk); verify("R12 idle after");

    // R10: offer together with a command is discarded
    clean(8'hFF);
    req_valid = 1; req_src = 24'h777; req_prio = 8'h01;
    do_cppr(8'h80, "R10 offer with priority write");
    req_valid = 1; req_src = 24'h778; req_prio = 8'h01;
    do_ipi(8'h40, "R10 offer with ipi write");
    // accept beats end of interrupt
    eoi_wr = 1; eoi_data = 32'h1000_0055;
    do_accept("R10 accept over eoi");
    // end of interrupt beats priority and ipi writes
    cppr_wr = 1; cppr_data = 8'h00; ipi_wr = 1; ipi_data = 8'h00;
    do_eoi(32'hFF00_0099, "R10 eoi over writes");
    // priority write beats ipi write
    ipi_wr = 1; ipi_data = 8'h00;
    do_cppr(8'h20, "R10 priority over ipi");

    // R12: pulses last one cycle
    do_req(24'h5, 8'h30, "R12 bounce");
    no_pulses();
    @(negedge clk); verify("R12 pulse gone");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule